// File: doc/BRIEF.md
# Nine-Slot Shared Memory Arbiter

Eight processor cores share one memory through a fixed rotation of nine clock slots. Slots 0 to 7 each belong to one core, and only that core may use memory in its slot. Slot 8 is shared. It goes to one requesting core, picked round-robin from a pointer that moves past each winner. In its own slot a core may also fetch an aligned eight-word line in a single access. A core that runs code from the shared memory uses this to load its next line of instructions.

A core raises its request together with an address, write data, a write enable and a wide-fetch flag. It holds them stable until it sees its grant bit, which is combinational in the same clock. A write completes at the end of the granted clock. Read data comes back one clock later on a shared 256-bit bus, qualified by the per-core valid strobe of the core that was granted. The memory is modelled inside the block as a synchronous array.

Top module: `nine_slot_arbiter`

## Requirements
- R1: While reset is held, and in the first clock after reset, the slot output is 0, the grant is zero and every read-valid strobe is low. The round-robin pointer starts at core 0, so the first shared slot after reset goes to the lowest-numbered eligible requester.
- R2: The slot output steps 0,1,...,8 and then wraps to 0, advancing once per clock.
- R3: In slot s (0 to 7), grant bit s is set exactly when request s is high, and no other grant bit is set.
- R4: In slot 8 the grant goes to the first eligible requester, searching upward with wrap from the pointer. The pointer then becomes the winner plus one, modulo 8. It is left unchanged when no core is eligible.
- R5: At most one grant bit is set in any clock.
- R6: A granted access with write enable 1 and wide flag 0 stores the write data at the word address at the end of that clock. A later read of that address returns it.
- R7: A granted single-word read (write enable 0, wide 0) raises only the granted core's read-valid bit in the next clock. The word is in rdata bits [31:0], and bits [255:32] are zero.
- R8: A granted wide fetch returns word j of the line in rdata bits [32*j+31:32*j]. Word j is the one at address {addr[5:3], j}, so the low three address bits are ignored. The write enable is ignored and memory is not changed.
- R9: A wide request is never eligible in slot 8. It stays pending until the core's own slot.
- R10: A granted write raises no read-valid strobe in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Per-core access request |
| addr | input | 48 | Per-core word address, core c in bits [6c+5:6c] |
| wdata | input | 256 | Per-core write data, core c in bits [32c+31:32c] |
| we | input | 8 | Per-core write enable |
| wide | input | 8 | Per-core eight-word line fetch flag |
| grant | output | 8 | One-hot grant for the current clock |
| slot | output | 4 | Current slot number, 0 to 8 |
| rvalid | output | 8 | Per-core read data valid, one clock after a read grant |
| rdata | output | 256 | Read data bus shared by all cores |

## Verification
The hardest state to reach is the round-robin pointer. A core that holds its request is served in its own slot before it can compete for the next shared slot, so the pointer can only be moved by requests raised during slot 8 itself. The stimulus therefore waits for slot 8, raises requests from chosen pairs of cores only for that clock, and drops them before their own slots come round. A round with no requester is followed by a pair that gives different winners depending on whether the pointer moved. A wide request raised in slot 8 is checked to get no grant and no read-valid strobe.

// File: rtl/nine_slot_pkg.sv
package nine_slot_pkg;
    localparam int NCORE  = 8;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 6;
    localparam int LINE_N = 8;
    localparam int SLOT_W = $clog2(NCORE + 1);
    localparam int CORE_W = $clog2(NCORE);
    localparam int LINE_W = $clog2(LINE_N);
endpackage

// File: rtl/nine_slot_timer.sv
module nine_slot_timer #(
    parameter int N     = 8,
    parameter int SLOTW = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SLOTW-1:0] slot
);
    typedef struct packed {
        logic [SLOTW-1:0] slot;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == SLOTW'(N)) st_d.slot = '0;
        else                        st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.slot;
endmodule

// File: rtl/shared_rr_pick.sv
module shared_rr_pick #(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [N-1:0] elig,
    output logic [N-1:0] pick
);
    typedef struct packed {
        logic [CW-1:0] ptr;
    } rr_t;

    rr_t           st_d, st_q;
    logic          found;
    logic [CW-1:0] win;

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            int k;
            k = (int'(st_q.ptr) + i) % N;
            if (!found && elig[k]) begin
                found = 1'b1;
                win   = CW'(k);
            end
        end
        pick = (active && found) ? (N'(1) << win) : '0;

        st_d = st_q;
        if (active && found)
            st_d.ptr = (win == CW'(N - 1)) ? '0 : win + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/line_mem.sv
module line_mem #(
    parameter int DW = 32,
    parameter int AW = 6,
    parameter int LN = 8,
    parameter int LW = $clog2(LN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           we,
    input  logic           wide,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [LN*DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem_q [DEPTH];
    logic [LN*DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (en && !we) begin
            rdata_d = '0;
            if (wide) begin
                for (int j = 0; j < LN; j++)
                    rdata_d[j*DW +: DW] = mem_q[{addr[AW-1:LW], LW'(j)}];
            end else begin
                rdata_d[DW-1:0] = mem_q[addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en && we) mem_q[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/nine_slot_arbiter.sv
module nine_slot_arbiter
    import nine_slot_pkg::*;
#(
    parameter int N     = NCORE,
    parameter int DW    = WORD_W,
    parameter int AW    = ADDR_W,
    parameter int LN    = LINE_N,
    parameter int SLOTW = $clog2(N + 1),
    parameter int CW    = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic [N*AW-1:0]   addr,
    input  logic [N*DW-1:0]   wdata,
    input  logic [N-1:0]      we,
    input  logic [N-1:0]      wide,
    output logic [N-1:0]      grant,
    output logic [SLOTW-1:0]  slot,
    output logic [N-1:0]      rvalid,
    output logic [LN*DW-1:0]  rdata
);
    typedef struct packed {
        logic [N-1:0] rvalid;
    } top_t;

    top_t          st_d, st_q;
    logic          is_shared;
    logic [N-1:0]  own_vec, shared_elig, pick;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic          sel_we, sel_wide, mem_en, mem_we;

    nine_slot_timer #(.N(N), .SLOTW(SLOTW)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot(slot)
    );

    assign is_shared   = (slot == SLOTW'(N));
    assign shared_elig = req & ~wide & {N{rst_n}};

    shared_rr_pick #(.N(N), .CW(CW)) u_rr (
        .clk(clk), .rst_n(rst_n), .active(is_shared),
        .elig(shared_elig), .pick(pick)
    );

    always_comb begin
        for (int c = 0; c < N; c++)
            own_vec[c] = rst_n && !is_shared && (slot == SLOTW'(c)) && req[c];
        grant = is_shared ? pick : own_vec;

        sel_addr  = '0;
        sel_wdata = '0;
        sel_we    = 1'b0;
        sel_wide  = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (grant[c]) begin
                sel_addr  = sel_addr  | addr[c*AW +: AW];
                sel_wdata = sel_wdata | wdata[c*DW +: DW];
                sel_we    = sel_we    | we[c];
                sel_wide  = sel_wide  | wide[c];
            end
        end
        mem_en = |grant;
        mem_we = sel_we && !sel_wide;

        st_d        = st_q;
        st_d.rvalid = (mem_en && !mem_we) ? grant : '0;
    end

    line_mem #(.DW(DW), .AW(AW), .LN(LN)) u_mem (
        .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we), .wide(sel_wide),
        .addr(sel_addr), .wdata(sel_wdata), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid = st_q.rvalid;
endmodule

// File: rtl/nine_slot_arbiter_chk.sv
module nine_slot_arbiter_chk #(
    parameter int N     = 8,
    parameter int SLOTW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic [N-1:0]     we,
    input logic [N-1:0]     wide,
    input logic [N-1:0]     grant,
    input logic [SLOTW-1:0] slot,
    input logic [N-1:0]     rvalid
);
    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot < SLOTW'(N)) |=> (slot == SLOTW'($past(slot) + 1'b1)));

    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOTW'(N)) |=> (slot == '0));

    a_r3_own_served: assert property (@(posedge clk) disable iff (!rst_n)
        (slot < SLOTW'(N) && req[slot[$clog2(N)-1:0]]) |-> grant[slot[$clog2(N)-1:0]]);

    a_r3_no_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (slot < SLOTW'(N) && grant != '0) |-> grant[slot[$clog2(N)-1:0]]);

    a_r4_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & we & ~wide) == '0) |=> (rvalid == $past(grant)));

    a_r9_no_shared_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOTW'(N)) |-> ((grant & wide) == '0));

    a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & we & ~wide) != '0) |=> (rvalid == '0));
endmodule

bind nine_slot_arbiter nine_slot_arbiter_chk #(.N(N), .SLOTW(SLOTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide),
    .grant(grant), .slot(slot), .rvalid(rvalid)
);

// File: tb/tb_nine_slot_arbiter.sv
module tb_nine_slot_arbiter;
    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int BW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0, we = '0, wide = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdata = '0;
    logic [N-1:0]  grant, rvalid;
    logic [3:0]    slot;
    logic [BW-1:0] rdata;

    int tests = 0;
    int fails = 0;

    nine_slot_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
        .we(we), .wide(wide), .grant(grant), .slot(slot),
        .rvalid(rvalid), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_slot(input int s);
        @(negedge clk);
        while (int'(slot) != s) @(negedge clk);
    endtask

    task automatic do_access(input int c, input int a, input logic [DW-1:0] d,
                             input logic w, input logic wd, output int gslot,
                             output logic [N-1:0] rv, output logic [BW-1:0] rd);
        req[c] = 1'b1;
        we[c] = w;
        wide[c] = wd;
        addr[c*AW +: AW] = AW'(a);
        wdata[c*DW +: DW] = d;
        gslot = -1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (grant[c]) begin
                gslot = int'(slot);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        rv = rvalid;
        rd = rdata;
        req[c] = 1'b0;
        we[c] = 1'b0;
        wide[c] = 1'b0;
    endtask

    task automatic t_reset;
        req = 8'h01;
        @(negedge clk);
        chk(slot == 0, "R1 slot in reset", BW'(slot), 0);
        chk(grant == 0, "R1 grant in reset", BW'(grant), 0);
        chk(rvalid == 0, "R1 rvalid in reset", BW'(rvalid), 0);
        req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(slot == 1, "R1 first slot after reset", BW'(slot), 1);
    endtask

    task automatic t_slot_seq;
        wait_slot(0);
        for (int i = 0; i < 18; i++) begin
            chk(int'(slot) == i % 9, "R2 slot sequence", BW'(slot), BW'(i % 9));
            @(negedge clk);
        end
    endtask

    task automatic t_write_read;
        int gs;
        logic [N-1:0] rv;
        logic [BW-1:0] rd;
        for (int c = 0; c < N; c++) begin
            logic [DW-1:0] d;
            d = 32'hA000_0000 | (32'h111 * c);
            wait_slot(c);
            do_access(c, c, d, 1'b1, 1'b0, gs, rv, rd);
            chk(gs == c, "R3 write granted in own slot", BW'(gs), BW'(c));
            chk(rv == 0, "R10 no rvalid after write", BW'(rv), 0);
            wait_slot(c);
            do_access(c, c, 32'h0, 1'b0, 1'b0, gs, rv, rd);
            chk(gs == c, "R3 read granted in own slot", BW'(gs), BW'(c));
            chk(rv == (N'(1) << c), "R7 rvalid of reader only", BW'(rv), BW'(N'(1) << c));
            chk(rd == BW'(d), "R6 R7 read returns written word", rd, BW'(d));
        end
    endtask

    task automatic t_wide;
        int gs;
        logic [N-1:0] rv;
        logic [BW-1:0] rd, exp;
        exp = '0;
        for (int j = 0; j < 8; j++) begin
            wait_slot(3);
            do_access(3, 40 + j, 32'hC0DE_0000 + j, 1'b1, 1'b0, gs, rv, rd);
            exp[j*DW +: DW] = 32'hC0DE_0000 + j;
        end
        wait_slot(3);
        do_access(3, 45, 32'h0, 1'b0, 1'b1, gs, rv, rd);
        chk(rv == 8'h08, "R8 wide rvalid", BW'(rv), BW'(8'h08));
        chk(rd == exp, "R8 wide line words", rd, exp);
        wait_slot(3);
        do_access(3, 40, 32'hDEAD_BEEF, 1'b1, 1'b1, gs, rv, rd);
        chk(rd == exp, "R8 wide ignores write enable", rd, exp);
        wait_slot(3);
        do_access(3, 40, 32'h0, 1'b0, 1'b0, gs, rv, rd);
        chk(rd == BW'(32'hC0DE_0000), "R8 memory unchanged", rd, BW'(32'hC0DE_0000));
    endtask

    task automatic shared_round(input logic [N-1:0] who, input logic [N-1:0] exp,
                                input string tag);
        wait_slot(8);
        for (int c = 0; c < N; c++) begin
            if (who[c]) begin
                req[c] = 1'b1;
                we[c] = 1'b0;
                addr[c*AW +: AW] = AW'(c);
            end
        end
        #1;
        chk(grant == exp, tag, BW'(grant), BW'(exp));
        @(negedge clk);
        chk(rvalid == exp, {tag, " rvalid"}, BW'(rvalid), BW'(exp));
        req = '0;
    endtask

    task automatic t_shared_rr;
        shared_round(8'h22, 8'h02, "R1 R4 first shared pick from core 0");
        shared_round(8'h22, 8'h20, "R4 pointer moved past winner");
        shared_round(8'h22, 8'h02, "R4 pointer wraps");
        shared_round(8'h00, 8'h00, "R4 idle shared slot");
        shared_round(8'h84, 8'h04, "R4 pointer held when idle");
    endtask

    task automatic t_shared_wide;
        wait_slot(8);
        req[4] = 1'b1;
        wide[4] = 1'b1;
        #1;
        chk(grant == 0, "R9 wide not granted in shared slot", BW'(grant), 0);
        @(negedge clk);
        chk(rvalid == 0, "R9 no rvalid for shared wide", BW'(rvalid), 0);
        req[4] = 1'b0;
        wide[4] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_slot_seq;
        t_write_read;
        t_wide;
        t_shared_rr;
        t_shared_wide;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule